// File: doc/BRIEF.md
# Interrupt Pending Status and In-Service Clear

This block is the status and control slice of a priority interrupt controller. It looks at per-channel request lines, each with a fixed priority level (0 is the highest of 16) and a class (ordinary or fast). It filters them through a per-channel mask, a per-group mask, a priority mask and the in-service register. It then reports in a status word why pending requests are not reaching the CPU. The three reasons are: held back only by the priority mask, ordinary requests stalled by the CPU's interrupt-disable flag, or fast requests stalled by the CPU's non-maskable-in-progress flag.

The in-service register records the levels the CPU has accepted, using a simple acknowledge input. The same acknowledge sets one of three in-progress flags. Software can wipe the in-service register and the in-progress flags only through a two-write unlock. First it writes all ones to the clear-enable register. Then it writes all zeros to the in-service register. Every other write to the in-service register leaves it untouched. A 16-bit register bus with a combinational read path gives access to every register.

Top module: `irq_pend_stat`

## Requirements
- R1: After a synchronous reset every readable register (channel mask, group mask, priority mask, in-service, clear-enable, status) reads 0.
- R2: Status bit 0 is 1 when some request is open (channel and group mask bits clear), is not in-service masked, and is priority masked. A level is priority masked when it is at or below (numerically at or above) the lowest-numbered set bit of the priority mask. An all-zero priority mask masks nothing.
- R3: Status bit 0 stays 0 when the only blocked requests are masked by their channel mask bit or group mask bit, or by an in-service bit at their own or a higher level. Channel c belongs to group c/(channels per group).
- R4: Status bit 1 is 1 when an ordinary-class request passes all masks and the CPU interrupt-disable input is 1. It is 0 while that input is 0.
- R5: Status bit 2 is 1 when a fast-class request passes all masks and the CPU non-maskable-in-progress input is 1. It is 0 while that input is 0.
- R6: The status word reflects inputs sampled at the previous clock edge, so it changes one cycle after its inputs. Bus writes to the status address change nothing.
- R7: An acknowledge sets in-service bit `ack_lvl_i` and a status in-progress flag. Kind 0 (ordinary) sets bit 4. Kind 1 (fast) sets bit 5. Kind 2 (fast non-maskable) sets only bit 6 and leaves the in-service register alone.
- R8: While the clear-enable register holds 0xFFFF, a write of 0x0000 to the in-service register clears that register and status bits 4 to 6, and returns clear-enable to 0. This clear wins over a simultaneous acknowledge.
- R9: While armed, an in-service write whose bits are not all zero leaves the in-service register unchanged and keeps the clear armed.
- R10: A write to the in-service register while the clear is not armed has no effect. Writing clear-enable with any value other than 0xFFFF stores that value and disarms the clear.
- R11: Register addresses are 0 channel mask, 1 group mask, 2 priority mask, 3 in-service, 4 clear-enable, 5 status. Writes land at the next clock edge, and reads return the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data of the addressed register |
| req_i | input | NUM_CH | Request lines |
| ch_lvl_i | input | NUM_CH*4 | Priority level of each channel |
| ch_fast_i | input | NUM_CH | 1 marks a fast-class channel |
| cpu_id_i | input | 1 | CPU ordinary interrupt disable |
| cpu_np_i | input | 1 | CPU non-maskable in progress |
| ack_vld_i | input | 1 | Acknowledge strobe |
| ack_kind_i | input | 2 | 0 ordinary, 1 fast, 2 fast non-maskable |
| ack_lvl_i | input | 4 | Level being acknowledged |
| stat_o | output | 7 | Status word (same as address 5) |

## Verification
Register writes land at the first clock edge after the strobe. The bench drives each write on a falling edge and reads back at the next falling edge. The pending flags pass through one register after the mask state they depend on. So the bench changes requests and CPU flags on the falling edge after the last mask write, then samples one edge later. It also samples once before that edge to confirm the old value still holds. Acknowledge effects and the clear sequence are checked one edge after their strobe. The hold cases of R9 and R10 are checked by reading both the in-service and the clear-enable registers after each rejected write.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
    localparam int unsigned LVL_N  = 16;
    localparam int unsigned LVL_W  = 4;
    localparam int unsigned BUS_W  = 16;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned STAT_W = 7;

    typedef enum logic [ADDR_W-1:0] {
        RA_CHMSK  = 3'd0,
        RA_GRPMSK = 3'd1,
        RA_PRIMSK = 3'd2,
        RA_INSVC  = 3'd3,
        RA_CLREN  = 3'd4,
        RA_STAT   = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        ACK_ORD  = 2'd0,
        ACK_FAST = 2'd1,
        ACK_FNMI = 2'd2
    } ack_kind_e;

    typedef struct packed {
        logic fast;
        logic ord;
        logic pmask;
    } pend_t;

    typedef struct packed {
        logic fnmi;
        logic fast;
        logic ord;
    } svc_t;
endpackage

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
    import irq_stat_pkg::*;
#(
    parameter int unsigned NUM_CH  = 8,
    parameter int unsigned NUM_GRP = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 we_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [BUS_W-1:0]     wdata_i,
    output logic [NUM_CH-1:0]    ch_mask_o,
    output logic [NUM_GRP-1:0]   grp_mask_o,
    output logic [LVL_N-1:0]     pri_mask_o
);
    typedef struct packed {
        logic [NUM_CH-1:0]  chm;
        logic [NUM_GRP-1:0] grp;
        logic [LVL_N-1:0]   pri;
    } mreg_t;

    mreg_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (we_i) begin
            unique case (addr_i)
                RA_CHMSK:  m_d.chm = wdata_i[NUM_CH-1:0];
                RA_GRPMSK: m_d.grp = wdata_i[NUM_GRP-1:0];
                RA_PRIMSK: m_d.pri = wdata_i[LVL_N-1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) m_q <= '0;
        else       m_q <= m_d;
    end

    assign ch_mask_o  = m_q.chm;
    assign grp_mask_o = m_q.grp;
    assign pri_mask_o = m_q.pri;

    // R11: a write to the priority mask address is visible one edge later
    p_pri_write_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        (we_i && addr_i == RA_PRIMSK) |=> (pri_mask_o == $past(wdata_i)));
endmodule

// File: rtl/irq_pend_eval.sv
module irq_pend_eval
    import irq_stat_pkg::*;
#(
    parameter int unsigned NUM_CH  = 8,
    parameter int unsigned NUM_GRP = 2
) (
    input  logic [NUM_CH-1:0]       req_i,
    input  logic [NUM_CH*LVL_W-1:0] ch_lvl_i,
    input  logic [NUM_CH-1:0]       ch_fast_i,
    input  logic [NUM_CH-1:0]       ch_mask_i,
    input  logic [NUM_GRP-1:0]      grp_mask_i,
    input  logic [LVL_N-1:0]        pri_mask_i,
    input  logic [LVL_N-1:0]        insvc_i,
    input  logic                    cpu_id_i,
    input  logic                    cpu_np_i,
    output pend_t                   pend_o
);
    localparam int unsigned CH_PER_GRP = NUM_CH / NUM_GRP;

    int   thr;
    logic pm_any;
    logic fwd_ord, fwd_fast, pm_hit;

    always_comb begin
        thr    = LVL_N;
        pm_any = |pri_mask_i;
        for (int k = LVL_N - 1; k >= 0; k--) begin
            if (pri_mask_i[k]) thr = k;
        end
    end

    always_comb begin
        pm_hit   = 1'b0;
        fwd_ord  = 1'b0;
        fwd_fast = 1'b0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            int   lv;
            logic open_c, isv_c, pm_c;
            lv     = 32'(ch_lvl_i[ch*LVL_W +: LVL_W]);
            open_c = req_i[ch] && !ch_mask_i[ch] && !grp_mask_i[ch / CH_PER_GRP];
            isv_c  = 1'b0;
            for (int j = 0; j < LVL_N; j++) begin
                if (insvc_i[j] && j <= lv) isv_c = 1'b1;
            end
            pm_c = pm_any && (lv >= thr);
            if (open_c && !isv_c) begin
                if (pm_c)              pm_hit   = 1'b1;
                else if (ch_fast_i[ch]) fwd_fast = 1'b1;
                else                    fwd_ord  = 1'b1;
            end
        end
    end

    assign pend_o.pmask = pm_hit;
    assign pend_o.ord   = fwd_ord  & cpu_id_i;
    assign pend_o.fast  = fwd_fast & cpu_np_i;
endmodule

// File: rtl/irq_svc_clear.sv
module irq_svc_clear
    import irq_stat_pkg::*;
#(
    parameter int unsigned CLR_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    input  logic              ack_vld_i,
    input  logic [1:0]        ack_kind_i,
    input  logic [LVL_W-1:0]  ack_lvl_i,
    output logic [LVL_N-1:0]  insvc_o,
    output logic [CLR_W-1:0]  clren_o,
    output svc_t              svc_o
);
    typedef struct packed {
        logic [LVL_N-1:0] insvc;
        logic [CLR_W-1:0] clren;
        svc_t             svc;
    } sreg_t;

    sreg_t s_d, s_q;
    logic  armed, wr_isv, wr_ce, isv_zero;

    always_comb begin
        armed    = &s_q.clren;
        wr_isv   = we_i && (addr_i == RA_INSVC);
        wr_ce    = we_i && (addr_i == RA_CLREN);
        isv_zero = (wdata_i[LVL_N-1:0] == '0);

        s_d = s_q;
        if (wr_ce) s_d.clren = wdata_i[CLR_W-1:0];
        if (ack_vld_i) begin
            unique case (ack_kind_i)
                ACK_ORD:  begin s_d.insvc[ack_lvl_i] = 1'b1; s_d.svc.ord  = 1'b1; end
                ACK_FAST: begin s_d.insvc[ack_lvl_i] = 1'b1; s_d.svc.fast = 1'b1; end
                ACK_FNMI: s_d.svc.fnmi = 1'b1;
                default:  ;
            endcase
        end
        if (wr_isv && armed && isv_zero) begin
            s_d.insvc = '0;
            s_d.svc   = '0;
            s_d.clren = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    assign insvc_o = s_q.insvc;
    assign clren_o = s_q.clren;
    assign svc_o   = s_q.svc;

    // R8: armed all-zero write wipes in-service state and disarms
    p_clear_seq_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_isv && armed && isv_zero) |=> (insvc_o == '0 && clren_o == '0 && svc_o == '0));

    // R9: armed non-zero write leaves the register and the arming alone
    p_mixed_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_isv && armed && !isv_zero && !ack_vld_i) |=> ($stable(insvc_o) && (&clren_o)));

    // R10: unarmed write to the in-service register has no effect
    p_unarmed_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_isv && !armed && !ack_vld_i) |=> $stable(insvc_o));
endmodule

// File: rtl/irq_pend_stat.sv
module irq_pend_stat
    import irq_stat_pkg::*;
#(
    parameter int unsigned NUM_CH  = 8,
    parameter int unsigned NUM_GRP = 2,
    parameter int unsigned CLR_W   = 16
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    bus_we_i,
    input  logic [ADDR_W-1:0]       bus_addr_i,
    input  logic [BUS_W-1:0]        bus_wdata_i,
    output logic [BUS_W-1:0]        bus_rdata_o,
    input  logic [NUM_CH-1:0]       req_i,
    input  logic [NUM_CH*LVL_W-1:0] ch_lvl_i,
    input  logic [NUM_CH-1:0]       ch_fast_i,
    input  logic                    cpu_id_i,
    input  logic                    cpu_np_i,
    input  logic                    ack_vld_i,
    input  logic [1:0]              ack_kind_i,
    input  logic [LVL_W-1:0]        ack_lvl_i,
    output logic [STAT_W-1:0]       stat_o
);
    logic [NUM_CH-1:0]  ch_mask;
    logic [NUM_GRP-1:0] grp_mask;
    logic [LVL_N-1:0]   pri_mask;
    logic [LVL_N-1:0]   insvc;
    logic [CLR_W-1:0]   clren;
    svc_t               svc;
    pend_t              pend_c, pend_d, pend_q;

    irq_mask_regs #(.NUM_CH(NUM_CH), .NUM_GRP(NUM_GRP)) u_masks (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .we_i       (bus_we_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .ch_mask_o  (ch_mask),
        .grp_mask_o (grp_mask),
        .pri_mask_o (pri_mask)
    );

    irq_pend_eval #(.NUM_CH(NUM_CH), .NUM_GRP(NUM_GRP)) u_eval (
        .req_i      (req_i),
        .ch_lvl_i   (ch_lvl_i),
        .ch_fast_i  (ch_fast_i),
        .ch_mask_i  (ch_mask),
        .grp_mask_i (grp_mask),
        .pri_mask_i (pri_mask),
        .insvc_i    (insvc),
        .cpu_id_i   (cpu_id_i),
        .cpu_np_i   (cpu_np_i),
        .pend_o     (pend_c)
    );

    irq_svc_clear #(.CLR_W(CLR_W)) u_svc (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .we_i       (bus_we_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .ack_vld_i  (ack_vld_i),
        .ack_kind_i (ack_kind_i),
        .ack_lvl_i  (ack_lvl_i),
        .insvc_o    (insvc),
        .clren_o    (clren),
        .svc_o      (svc)
    );

    always_comb pend_d = pend_c;

    always_ff @(posedge clk_i) begin
        if (rst_i) pend_q <= '0;
        else       pend_q <= pend_d;
    end

    assign stat_o = {svc, 1'b0, pend_q};

    always_comb begin
        bus_rdata_o = '0;
        unique case (bus_addr_i)
            RA_CHMSK:  bus_rdata_o[NUM_CH-1:0]  = ch_mask;
            RA_GRPMSK: bus_rdata_o[NUM_GRP-1:0] = grp_mask;
            RA_PRIMSK: bus_rdata_o              = pri_mask;
            RA_INSVC:  bus_rdata_o              = insvc;
            RA_CLREN:  bus_rdata_o[CLR_W-1:0]   = clren;
            RA_STAT:   bus_rdata_o[STAT_W-1:0]  = stat_o;
            default:   bus_rdata_o              = '0;
        endcase
    end

    // R4: with interrupts enabled the ordinary flag is clear one cycle later
    p_ord_gate_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        !cpu_id_i |=> !stat_o[1]);

    // R5: without a non-maskable in progress the fast flag is clear
    p_fast_gate_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !cpu_np_i |=> !stat_o[2]);

    // R3: every channel masked leaves no priority-only pending
    p_pm_chmask_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (&ch_mask) |=> !stat_o[0]);
endmodule

// File: tb/irq_pend_stat_tb_top.sv
`timescale 1ns/1ps
module irq_pend_stat_tb_top;
    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_i;
    logic        bus_we_i;
    logic [2:0]  bus_addr_i;
    logic [15:0] bus_wdata_i;
    logic [15:0] bus_rdata_o;
    logic [NCH-1:0]   req_i;
    logic [NCH*4-1:0] ch_lvl_i;
    logic [NCH-1:0]   ch_fast_i;
    logic        cpu_id_i, cpu_np_i;
    logic        ack_vld_i;
    logic [1:0]  ack_kind_i;
    logic [3:0]  ack_lvl_i;
    logic [6:0]  stat_o;

    int n_vec  = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    irq_pend_stat dut_i (
        .clk_i(clk), .rst_i(rst_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .req_i(req_i),
        .ch_lvl_i(ch_lvl_i), .ch_fast_i(ch_fast_i), .cpu_id_i(cpu_id_i),
        .cpu_np_i(cpu_np_i), .ack_vld_i(ack_vld_i), .ack_kind_i(ack_kind_i),
        .ack_lvl_i(ack_lvl_i), .stat_o(stat_o)
    );

    // {req, chmask, grpmask, primask, cpu_id, cpu_np, expected {fast,ord,pmask}}
    // channel c has level 2c; channels 4..7 are fast class
    localparam logic [38:0] VEC [12] = '{
        {8'h01, 8'h00, 2'b00, 16'h0000, 1'b0, 1'b0, 3'b000},
        {8'h01, 8'h00, 2'b00, 16'h0000, 1'b1, 1'b0, 3'b010},
        {8'h10, 8'h00, 2'b00, 16'h0000, 1'b0, 1'b1, 3'b100},
        {8'h10, 8'h00, 2'b00, 16'h0000, 1'b1, 1'b0, 3'b000},
        {8'h08, 8'h00, 2'b00, 16'h0040, 1'b0, 1'b0, 3'b001},
        {8'h08, 8'h00, 2'b00, 16'h0080, 1'b0, 1'b0, 3'b000},
        {8'h08, 8'h08, 2'b00, 16'h0040, 1'b0, 1'b0, 3'b000},
        {8'h08, 8'h00, 2'b01, 16'h0040, 1'b0, 1'b0, 3'b000},
        {8'h09, 8'h00, 2'b00, 16'h0010, 1'b1, 1'b0, 3'b011},
        {8'hF0, 8'h00, 2'b00, 16'h0001, 1'b0, 1'b1, 3'b001},
        {8'h80, 8'h00, 2'b10, 16'h8000, 1'b0, 1'b1, 3'b000},
        {8'hC0, 8'h40, 2'b00, 16'h8000, 1'b1, 1'b1, 3'b100}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_we_i = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [2:0] a, input logic [15:0] exp);
        bus_addr_i = a;
        #1;
        chk(tag, bus_rdata_o, exp);
    endtask

    task automatic ack(input logic [1:0] k, input logic [3:0] l);
        @(negedge clk);
        ack_vld_i = 1'b1; ack_kind_i = k; ack_lvl_i = l;
        @(negedge clk);
        ack_vld_i = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) ch_lvl_i[c*4 +: 4] = 4'(2*c);
        ch_fast_i = 8'hF0;
        rst_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = 3'd0; bus_wdata_i = '0;
        req_i = '0; cpu_id_i = 1'b0; cpu_np_i = 1'b0;
        ack_vld_i = 1'b0; ack_kind_i = 2'd0; ack_lvl_i = 4'd0;
        repeat (3) @(negedge clk);
        rst_i = 1'b0;

        // R1 reset state
        for (int a = 0; a < 6; a++) rd("R1 reset", 3'(a), 16'h0000);

        // R11 register readback
        wr(3'd0, 16'h00A5); rd("R11 chmask", 3'd0, 16'h00A5);
        wr(3'd1, 16'h0002); rd("R11 grpmask", 3'd1, 16'h0002);
        wr(3'd2, 16'h1230); rd("R11 primask", 3'd2, 16'h1230);

        // R2 R3 R4 R5 vector table
        for (int i = 0; i < 12; i++) begin
            logic [38:0] v;
            v = VEC[i];
            wr(3'd0, {8'h00, v[30:23]});
            wr(3'd1, {14'h0, v[22:21]});
            wr(3'd2, v[20:5]);
            req_i = v[38:31]; cpu_id_i = v[4]; cpu_np_i = v[3];
            @(negedge clk);
            rd($sformatf("R2/R3/R4/R5 vector %0d", i), 3'd5, {13'h0, v[2:0]});
        end

        wr(3'd0, 16'h0); wr(3'd1, 16'h0); wr(3'd2, 16'h0);
        req_i = '0; cpu_id_i = 1'b0; cpu_np_i = 1'b0;
        @(negedge clk);

        // R6 one-cycle latency and write-ignore
        req_i = 8'h01; cpu_id_i = 1'b1;
        rd("R6 before edge", 3'd5, 16'h0000);
        @(negedge clk);
        rd("R4 after edge", 3'd5, 16'h0002);
        wr(3'd5, 16'h007F);
        rd("R6 status write ignored", 3'd5, 16'h0002);
        req_i = '0; cpu_id_i = 1'b0;

        // R7 acknowledges
        ack(2'd0, 4'd3);
        rd("R7 ord insvc", 3'd3, 16'h0008);
        rd("R7 ord flag", 3'd5, 16'h0010);
        ack(2'd1, 4'd9);
        rd("R7 fast insvc", 3'd3, 16'h0208);
        rd("R7 fast flag", 3'd5, 16'h0030);
        ack(2'd2, 4'd0);
        rd("R7 fnmi insvc", 3'd3, 16'h0208);
        rd("R7 fnmi flag", 3'd5, 16'h0070);

        // R3 in-service masking, R2 lower level not covered
        wr(3'd2, 16'h0040);
        req_i = 8'h08;
        @(negedge clk);
        rd("R3 insvc masks level", 3'd5, 16'h0070);
        wr(3'd2, 16'h0001);
        req_i = 8'h02;
        @(negedge clk);
        rd("R2 above insvc", 3'd5, 16'h0071);
        req_i = '0;
        wr(3'd2, 16'h0000);

        // R10 unarmed writes and disarming
        wr(3'd3, 16'h0000);
        rd("R10 unarmed write", 3'd3, 16'h0208);
        wr(3'd4, 16'hFFFF);
        rd("R10 armed readback", 3'd4, 16'hFFFF);
        wr(3'd4, 16'h1234);
        rd("R10 disarm value", 3'd4, 16'h1234);
        wr(3'd3, 16'h0000);
        rd("R10 disarmed write", 3'd3, 16'h0208);

        // R9 non-uniform and all-one writes while armed
        wr(3'd4, 16'hFFFF);
        wr(3'd3, 16'h00F0);
        rd("R9 mixed insvc", 3'd3, 16'h0208);
        rd("R9 still armed", 3'd4, 16'hFFFF);
        wr(3'd3, 16'hFFFF);
        rd("R9 ones insvc", 3'd3, 16'h0208);

        // R8 armed clear
        wr(3'd3, 16'h0000);
        rd("R8 insvc cleared", 3'd3, 16'h0000);
        rd("R8 clren auto zero", 3'd4, 16'h0000);
        rd("R8 flags cleared", 3'd5, 16'h0000);
        chk("R8 stat port", {9'h0, stat_o}, 16'h0000);

        // R1 reset mid-run
        ack(2'd0, 4'd5);
        wr(3'd0, 16'h0033);
        @(negedge clk);
        rst_i = 1'b1;
        @(negedge clk);
        rst_i = 1'b0;
        rd("R1 insvc after reset", 3'd3, 16'h0000);
        rd("R1 chmask after reset", 3'd0, 16'h0000);
        rd("R1 status after reset", 3'd5, 16'h0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule